// File: doc/BRIEF.md
# PCI Master Preemption Controller

This block sequences the bus-master side of a parallel PCI-style bus. It raises a bus request, waits for the arbiter's grant, and then drives the frame and initiator-ready strobes through one address phase and one or more data phases. It also decides how to give the bus back when the arbiter withdraws the grant part way through. All bus strobes in this model are active high, and the address/data path is reduced to a counter of completed data phases.

A job is handed over with a single start pulse while the block is idle. In single-phase mode the job length is a number of transactions, each with exactly one data phase, run one after another. In burst mode the job length is a number of data phases, sent as one transaction per bus ownership. In burst mode a latency timer, loaded from a configuration input at each address phase, decides whether a lost grant is acted on. An extended-request option decides whether the request line stays high across a forced release. A target abort stops the job, latches two status flags and can raise an interrupt line.

Top module: `pci_mst_preempt`

## Requirements
- R1: In single-phase mode, `req_o` is high in the cycle in which `frame_o` rises for every transaction except the last one of the job, and low in the cycle in which it rises for the last one.
- R2: In single-phase mode, when the grant is lost the current transaction still completes with its one data phase (frame low, ready high) and the bus is then released. If transactions remain, `req_o` stays high in the release cycle.
- R3: In burst mode only one transaction runs per ownership. After a release with data phases left, the next address phase is preceded by at least one cycle that waits for a grant, even if the grant is already back. Single-phase mode may start its next address phase straight from the release cycle.
- R4: In burst mode, a low `gnt_i` is ignored and data phases continue while the latency timer is non-zero.
- R5: In burst mode, when a data phase completes while the timer is zero and `gnt_i` is low, `frame_o` drops while `irdy_o` stays high for exactly one final data phase. Both are then low in the release cycle.
- R6: After a burst release with phases left, `job_ext_i`=0 gives `req_o` low through the ownership and the release cycle and high again in the very next cycle. `job_ext_i`=1 keeps `req_o` high throughout.
- R7: The latency timer loads `lat_cfg_i` when an address phase begins, counts down once per cycle of ownership, and stays at zero once there. With a value C, a burst that has lost its grant ends after max(C,1)+1 data phases, or after its full length if that is shorter.
- R8: A target abort during a data phase drops `frame_o` first, then drops `irdy_o` one cycle later. No data phase is counted for the aborted cycle, the remaining work is discarded, and `req_o` stays low until a new job starts.
- R9: A target abort sets `rx_tabort_o` and `sys_int_o`. Writing 1 on `flag_clr_i[0]` clears `rx_tabort_o` and writing 1 on `flag_clr_i[1]` clears `sys_int_o`. A set in the same cycle overrides a clear.
- R10: `irq_n_o` is low exactly when `sys_int_o` is 1 and `int_en_i` is 1, and high otherwise.
- R11: After reset, `req_o`, `frame_o`, `irdy_o`, `beats_o`, `rx_tabort_o` and `sys_int_o` are 0 and `irq_n_o` is 1.
- R12: `beats_o` is cleared at job start and counts data phases completed (ready and target ready both high). When a job finishes it equals the job length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_start_i | input | 1 | Start pulse, accepted only while idle and with a non-zero length |
| job_burst_i | input | 1 | 1 = burst mode, 0 = single-phase mode |
| job_ext_i | input | 1 | Extended-request option for burst mode |
| job_len_i | input | LEN_W | Transactions (single-phase mode) or data phases (burst mode) |
| lat_cfg_i | input | LAT_W | Latency timer reload value |
| gnt_i | input | 1 | Grant from the central arbiter |
| trdy_i | input | 1 | Target ready |
| tabort_i | input | 1 | Target abort indication |
| int_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 abort status, bit 1 interrupt flag |
| req_o | output | 1 | Bus request |
| frame_o | output | 1 | Frame strobe |
| irdy_o | output | 1 | Initiator ready |
| beats_o | output | LEN_W | Completed data phases of the current job |
| rx_tabort_o | output | 1 | Received-target-abort status |
| sys_int_o | output | 1 | System interrupt flag |
| irq_n_o | output | 1 | Interrupt line, active low |

## Verification
A vector table runs jobs in which the arbiter pulls the grant in the cycle right after the first address phase. The rows vary the mode, the job length, the timer value and the extended-request bit. Rows with short and long timer values show whether a lost grant is honoured or ignored. Rows whose length ends before the timer runs out show the normal end separately from a forced one. Paired single-phase and burst rows show whether re-entry to the bus goes straight to an address phase or through a wait for grant. Directed runs then hold the grant for a full single-phase job to probe the request line at each frame start, and inject target aborts with and without simultaneous clears to exercise the flags and the interrupt gating.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ADDR,
      ST_DATA,
      ST_LAST,
      ST_ABT,
      ST_REL
   } pmp_state_e;
endpackage

// File: rtl/pmp_lat_timer.sv
module pmp_lat_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LAT_W-1:0] cfg_i,
   input  logic             own_i,
   output logic             zero_o
);
   logic [LAT_W-1:0] cnt_q;

   generate
      if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
         $error("pmp_lat_timer: LAT_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= cfg_i;
      else if (own_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   AST_LAT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && zero_o) |=> zero_o); // R7
endmodule

// File: rtl/pmp_seq.sv
module pmp_seq
   import pmp_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             job_start_i,
   input  logic             job_burst_i,
   input  logic             job_ext_i,
   input  logic [LEN_W-1:0] job_len_i,
   input  logic             gnt_i,
   input  logic             trdy_i,
   input  logic             tabort_i,
   input  logic             lat_zero_i,
   output logic             req_o,
   output logic             frame_o,
   output logic             irdy_o,
   output logic             lat_load_o,
   output logic             own_o,
   output logic             abort_evt_o,
   output logic [LEN_W-1:0] beats_o
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

   pmp_state_e       st_q, st_d;
   logic [LEN_W-1:0] work_q, work_d;
   logic [LEN_W-1:0] beats_q, beats_d;
   logic             burst_q, burst_d;
   logic             ext_q, ext_d;
   logic             in_phase;

   assign in_phase = (st_q == ST_DATA) || (st_q == ST_LAST);

   always_comb begin
      st_d    = st_q;
      work_d  = work_q;
      beats_d = beats_q;
      burst_d = burst_q;
      ext_d   = ext_q;
      case (st_q)
         ST_IDLE: begin
            if (job_start_i && job_len_i != '0) begin
               work_d  = job_len_i;
               burst_d = job_burst_i;
               ext_d   = job_ext_i;
               beats_d = '0;
               st_d    = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (gnt_i) st_d = ST_ADDR;
         end
         ST_ADDR: begin
            st_d = (burst_q && work_q > ONE) ? ST_DATA : ST_LAST;
         end
         ST_DATA: begin
            if (tabort_i) begin
               work_d = '0;
               st_d   = ST_ABT;
            end else if (trdy_i) begin
               work_d  = work_q - ONE;
               beats_d = beats_q + ONE;
               if (work_q == TWO || (lat_zero_i && !gnt_i)) st_d = ST_LAST;
            end
         end
         ST_LAST: begin
            if (tabort_i) begin
               work_d = '0;
               st_d   = ST_IDLE;
            end else if (trdy_i) begin
               work_d  = work_q - ONE;
               beats_d = beats_q + ONE;
               st_d    = ST_REL;
            end
         end
         ST_ABT: st_d = ST_IDLE;
         ST_REL: begin
            if (work_q == '0)  st_d = ST_IDLE;
            else if (burst_q)  st_d = ST_WAIT;
            else if (gnt_i)    st_d = ST_ADDR;
            else               st_d = ST_WAIT;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         work_q  <= '0;
         beats_q <= '0;
         burst_q <= 1'b0;
         ext_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         work_q  <= work_d;
         beats_q <= beats_d;
         burst_q <= burst_d;
         ext_q   <= ext_d;
      end
   end

   always_comb begin
      case (st_q)
         ST_WAIT:                    req_o = 1'b1;
         ST_ADDR, ST_DATA, ST_LAST,
         ST_ABT:                     req_o = burst_q ? (ext_q && work_q != '0) : (work_q > ONE);
         ST_REL:                     req_o = burst_q ? (ext_q && work_q != '0) : (work_q != '0);
         default:                    req_o = 1'b0;
      endcase
   end

   assign frame_o     = (st_q == ST_ADDR) || (st_q == ST_DATA);
   assign irdy_o      = in_phase || (st_q == ST_ABT);
   assign own_o       = frame_o || irdy_o;
   assign lat_load_o  = (st_q == ST_WAIT || st_q == ST_REL) && (st_d == ST_ADDR);
   assign abort_evt_o = tabort_i && in_phase;
   assign beats_o     = beats_q;

   AST_FRAME_ENDS_WITH_IRDY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_o) |-> irdy_o); // R5
   AST_IRDY_DROPS_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irdy_o) |-> $past(!frame_o)); // R8
   AST_ABORT_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt_o |=> !frame_o); // R8
   AST_BURST_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && !lat_zero_i && trdy_i && !tabort_i && work_q > TWO)
         |=> (st_q == ST_DATA)); // R4
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (!req_o && !frame_o && !irdy_o)); // R11
endmodule

// File: rtl/pmp_status.sv
module pmp_status #(
   parameter bit IRQ_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort_evt_i,
   input  logic [1:0] clr_i,
   input  logic       int_en_i,
   output logic       rx_tabort_o,
   output logic       sys_int_o,
   output logic       irq_o
);
   logic rx_q, sys_q, irq_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= 1'b0;
         sys_q <= 1'b0;
      end else begin
         rx_q  <= abort_evt_i || (rx_q  && !clr_i[0]);
         sys_q <= abort_evt_i || (sys_q && !clr_i[1]);
      end
   end

   assign irq_act     = sys_q && int_en_i;
   assign rx_tabort_o = rx_q;
   assign sys_int_o   = sys_q;

   generate
      if (IRQ_ACTIVE_LOW) begin : g_irq_low
         assign irq_o = ~irq_act;
      end else begin : g_irq_high
         assign irq_o = irq_act;
      end
   endgenerate

   AST_INT_NEEDS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_q) |-> $past(abort_evt_i)); // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en_i |-> (irq_o == IRQ_ACTIVE_LOW)); // R10
endmodule

// File: rtl/pci_mst_preempt.sv
module pci_mst_preempt #(
   parameter int LEN_W = 8,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             job_start_i,
   input  logic             job_burst_i,
   input  logic             job_ext_i,
   input  logic [LEN_W-1:0] job_len_i,
   input  logic [LAT_W-1:0] lat_cfg_i,
   input  logic             gnt_i,
   input  logic             trdy_i,
   input  logic             tabort_i,
   input  logic             int_en_i,
   input  logic [1:0]       flag_clr_i,
   output logic             req_o,
   output logic             frame_o,
   output logic             irdy_o,
   output logic [LEN_W-1:0] beats_o,
   output logic             rx_tabort_o,
   output logic             sys_int_o,
   output logic             irq_n_o
);
   generate
      if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
         $error("pci_mst_preempt: LEN_W out of range");
      end
   endgenerate

   logic lat_load, lat_zero, own, abort_evt;

   pmp_seq #(.LEN_W(LEN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .job_start_i (job_start_i),
      .job_burst_i (job_burst_i),
      .job_ext_i   (job_ext_i),
      .job_len_i   (job_len_i),
      .gnt_i       (gnt_i),
      .trdy_i      (trdy_i),
      .tabort_i    (tabort_i),
      .lat_zero_i  (lat_zero),
      .req_o       (req_o),
      .frame_o     (frame_o),
      .irdy_o      (irdy_o),
      .lat_load_o  (lat_load),
      .own_o       (own),
      .abort_evt_o (abort_evt),
      .beats_o     (beats_o)
   );

   pmp_lat_timer #(.LAT_W(LAT_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (lat_load),
      .cfg_i  (lat_cfg_i),
      .own_i  (own),
      .zero_o (lat_zero)
   );

   pmp_status #(.IRQ_ACTIVE_LOW(1'b1)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_evt_i (abort_evt),
      .clr_i       (flag_clr_i),
      .int_en_i    (int_en_i),
      .rx_tabort_o (rx_tabort_o),
      .sys_int_o   (sys_int_o),
      .irq_o       (irq_n_o)
   );
endmodule

// File: tb/pci_mst_preempt_tb.sv
module pci_mst_preempt_tb;
   localparam time CLK_PERIOD = 20ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       job_start = 1'b0, job_burst = 1'b0, job_ext = 1'b0;
   logic [7:0] job_len = '0, lat_cfg = '0;
   logic       gnt = 1'b0, trdy = 1'b1, tabort = 1'b0, int_en = 1'b0;
   logic [1:0] flag_clr = '0;
   logic       req_o, frame_o, irdy_o, rx_tabort_o, sys_int_o, irq_n_o;
   logic [7:0] beats_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_mst_preempt u_dut (
      .clk(clk), .rst_n(rst_n), .job_start_i(job_start), .job_burst_i(job_burst),
      .job_ext_i(job_ext), .job_len_i(job_len), .lat_cfg_i(lat_cfg), .gnt_i(gnt),
      .trdy_i(trdy), .tabort_i(tabort), .int_en_i(int_en), .flag_clr_i(flag_clr),
      .req_o(req_o), .frame_o(frame_o), .irdy_o(irdy_o), .beats_o(beats_o),
      .rx_tabort_o(rx_tabort_o), .sys_int_o(sys_int_o), .irq_n_o(irq_n_o)
   );

   typedef struct packed {
      logic       burst;
      logic       ext;
      logic [7:0] len;
      logic [7:0] lat;
      logic [7:0] exp_beats;   // phases done when the first release is seen
      logic       exp_req_rel; // req_o in the release cycle
      logic       exp_frm_nxt; // frame_o one cycle after release (grant back)
      logic       exp_req_nxt; // req_o one cycle after release
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b0, 8'd8, 8'd0,  8'd2, 1'b0, 1'b0, 1'b1},
      '{1'b1, 1'b1, 8'd8, 8'd3,  8'd4, 1'b1, 1'b0, 1'b1},
      '{1'b1, 1'b1, 8'd4, 8'd10, 8'd4, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b0, 8'd5, 8'd2,  8'd3, 1'b0, 1'b0, 1'b1},
      '{1'b0, 1'b0, 8'd3, 8'd0,  8'd1, 1'b1, 1'b1, 1'b1},
      '{1'b0, 1'b0, 8'd1, 8'd0,  8'd1, 1'b0, 1'b0, 1'b0},
      '{1'b1, 1'b1, 8'd2, 8'd0,  8'd2, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic start_job(input logic b, input logic e, input logic [7:0] l, input logic [7:0] c);
      @(negedge clk);
      job_start = 1'b1; job_burst = b; job_ext = e; job_len = l; lat_cfg = c;
      @(negedge clk);
      job_start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      logic pf, pi, found;
      int   nfr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11 req", req_o, 0);
      chk("R11 frame", frame_o, 0);
      chk("R11 irdy", irdy_o, 0);
      chk("R11 beats", beats_o, 0);
      chk("R11 flags", {rx_tabort_o, sys_int_o}, 0);
      chk("R11 irq", irq_n_o, 1);

      // Table: arbiter removes the grant right after the first address phase
      for (int v = 0; v < NVEC; v++) begin
         gnt = 1'b1;
         start_job(VECS[v].burst, VECS[v].ext, VECS[v].len, VECS[v].lat);
         pf = 1'b0; pi = 1'b0; found = 1'b0;
         for (int c = 0; c < 100 && !found; c++) begin
            @(negedge clk);
            if (pi && !irdy_o) begin
               found = 1'b1;
               chk($sformatf("R4 R7 beats at release v%0d", v), beats_o, VECS[v].exp_beats);
               chk($sformatf("R2 R6 req at release v%0d", v), req_o, VECS[v].exp_req_rel);
               chk($sformatf("R5 frame low in final phase v%0d", v), pf, 0);
               gnt = 1'b1;
            end else begin
               if (frame_o) gnt = 1'b0;
               pf = frame_o;
               pi = irdy_o;
            end
         end
         chk($sformatf("R5 release seen v%0d", v), found, 1);
         @(negedge clk);
         chk($sformatf("R3 frame after release v%0d", v), frame_o, VECS[v].exp_frm_nxt);
         chk($sformatf("R6 req after release v%0d", v), req_o, VECS[v].exp_req_nxt);
         repeat (60) @(negedge clk);
         chk($sformatf("R12 total beats v%0d", v), beats_o, VECS[v].len);
         chk($sformatf("R12 idle req v%0d", v), req_o, 0);
      end

      // R1: single-phase job of 3 with grant held
      gnt = 1'b1;
      start_job(1'b0, 1'b0, 8'd3, 8'd0);
      pf = 1'b0; nfr = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (frame_o && !pf) begin
            nfr++;
            chk($sformatf("R1 req at frame start %0d", nfr), req_o, (nfr < 3) ? 1 : 0);
         end
         pf = frame_o;
      end
      chk("R1 frame starts", nfr, 3);
      chk("R12 single-phase beats", beats_o, 3);

      // R8/R9/R10: target abort during a burst
      start_job(1'b1, 1'b0, 8'd8, 8'd10);
      for (int c = 0; c < 40 && beats_o != 8'd2; c++) @(negedge clk);
      tabort = 1'b1; trdy = 1'b0;
      @(negedge clk);
      chk("R8 frame drops first", frame_o, 0);
      chk("R8 irdy held one cycle", irdy_o, 1);
      tabort = 1'b0; trdy = 1'b1;
      @(negedge clk);
      chk("R8 irdy dropped", irdy_o, 0);
      repeat (10) @(negedge clk);
      chk("R8 no re-request", req_o, 0);
      chk("R8 no further phases", beats_o, 2);
      chk("R9 abort status set", rx_tabort_o, 1);
      chk("R9 interrupt flag set", sys_int_o, 1);
      chk("R10 irq masked", irq_n_o, 1);
      int_en = 1'b1;
      @(negedge clk);
      chk("R10 irq active", irq_n_o, 0);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      chk("R9 status cleared", rx_tabort_o, 0);
      chk("R9 int flag kept", sys_int_o, 1);
      chk("R10 irq still active", irq_n_o, 0);
      flag_clr = 2'b10;
      @(negedge clk);
      flag_clr = 2'b00;
      chk("R9 int flag cleared", sys_int_o, 0);
      chk("R10 irq released", irq_n_o, 1);

      // R9: set overrides a simultaneous clear
      start_job(1'b1, 1'b0, 8'd4, 8'd10);
      for (int c = 0; c < 40 && beats_o != 8'd1; c++) @(negedge clk);
      tabort = 1'b1; trdy = 1'b0; flag_clr = 2'b11;
      @(negedge clk);
      tabort = 1'b0; trdy = 1'b1; flag_clr = 2'b00;
      chk("R9 set wins status", rx_tabort_o, 1);
      chk("R9 set wins int", sys_int_o, 1);
      repeat (3) @(negedge clk);

      done = 1'b1;
      finish_run();
   end
endmodule